// File: doc/BRIEF.md
# Accumulator Read Limiter and Rounder

This block produces the word that goes onto a data bus when a move instruction reads a wide accumulator. The accumulator is split into three fields: a signed extension field at the top, a high word and a low word. A full read returns the high word. When rounding is enabled, the block first rounds to nearest at the word boundary. If the rounded value does not fit in one signed word, the block saturates it to the largest positive or the largest negative word. The block can also return a single field unchanged.

Every read is registered. The result appears one clock after the read strobe, together with a valid pulse. Two sticky status flags go to the condition code register. The limit flag records that a full read was saturated. The growth flag records that a full read saw a value that had spread past the top bit of the high word. Both flags stay set until the clear input is asserted.

Top module: `acc_read_limiter`

## Requirements
- R1: `bus_valid` is high exactly in the cycle after a cycle with `rd_req` high. `bus_data` is loaded only on a request and otherwise holds its last value.
- R2: A full read (`rd_sel` = 0) without rounding, of a value that fits in one signed word, returns the high word, accumulator bits [47:24].
- R3: When the extension bits [55:48] and bit 47 are not all equal after rounding, a full read saturates. It returns 0x7FFFFF if the value is positive and 0x800000 if it is negative.
- R4: A saturated full read sets `flag_limit`. The flag stays set over later reads until it is cleared.
- R5: A full read with accumulator bit 47 different from bit 46 sets `flag_growth`. The flag is sticky. The check uses the unrounded value.
- R6: With `round_en` high, a full read adds one at accumulator bit 23 and then truncates. Saturation is applied to the rounded value, so a carry out of the high word saturates and sets `flag_limit`.
- R7: Field reads return a field unchanged, with no saturation or rounding, and leave both flags as they were. `rd_sel` = 1 returns the extension sign-extended to 24 bits, `rd_sel` = 2 returns the high word and `rd_sel` = 3 returns the low word.
- R8: `flag_clr` clears both flags in the next cycle. Clearing takes priority over a full read that would set a flag in the same cycle.
- R9: After reset, `bus_data` is 0 and `bus_valid`, `flag_limit` and `flag_growth` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Read strobe from a move |
| rd_sel | input | 2 | 0 full, 1 extension, 2 high word, 3 low word |
| round_en | input | 1 | Round to nearest on full reads |
| flag_clr | input | 1 | Clear both sticky flags |
| acc_in | input | 56 | Accumulator value being read |
| bus_data | output | 24 | Registered bus word |
| bus_valid | output | 1 | Bus word valid, one clock after the strobe |
| flag_limit | output | 1 | Sticky saturation flag |
| flag_growth | output | 1 | Sticky growth flag |

## Verification
The hardest case to reach is saturation caused only by rounding: an in-range high word that the rounding carry pushes out of range. The stimulus reaches it with a value whose high word is 0x7FFFFF and whose low word has its top bit set. The same value read with rounding off is also applied, to show that only the carry causes the saturation. Sticky behaviour is observed only through the ports. Field reads placed after flag-setting full reads and after clears show the held flag state without disturbing it. A clear and a saturating full read are also issued in the same cycle to test the priority between them.

// File: rtl/acc_read_limiter.sv
module acc_read_limiter #(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_req,
  input  logic [1:0]                  rd_sel,
  input  logic                        round_en,
  input  logic                        flag_clr,
  input  logic [EXT_W+2*WORD_W-1:0]   acc_in,
  output logic [WORD_W-1:0]           bus_data,
  output logic                        bus_valid,
  output logic                        flag_limit,
  output logic                        flag_growth
);
  localparam int ACC_W = EXT_W + 2*WORD_W;
  localparam int TOP_W = EXT_W + WORD_W + 1;
  localparam logic [1:0] SEL_FULL = 2'd0;
  localparam logic [1:0] SEL_EXT  = 2'd1;
  localparam logic [1:0] SEL_HIGH = 2'd2;

  logic [TOP_W-1:0]  top_sum;
  logic [EXT_W+1:0]  guard;
  logic              over, grow, full_rd;
  logic [WORD_W-1:0] sat_word, full_word, next_word;

  assign top_sum = {acc_in[ACC_W-1], acc_in[ACC_W-1:WORD_W]}
                 + TOP_W'(round_en & acc_in[WORD_W-1]);
  assign guard   = top_sum[TOP_W-1:WORD_W-1];
  assign over    = !((&guard) || !(|guard));
  assign sat_word = top_sum[TOP_W-1] ? {1'b1, {(WORD_W-1){1'b0}}}
                                     : {1'b0, {(WORD_W-1){1'b1}}};
  assign full_word = over ? sat_word : top_sum[WORD_W-1:0];
  assign grow    = acc_in[2*WORD_W-1] ^ acc_in[2*WORD_W-2];
  assign full_rd = rd_req && (rd_sel == SEL_FULL);

  always_comb begin
    case (rd_sel)
      SEL_FULL: next_word = full_word;
      SEL_EXT:  next_word = {{(WORD_W-EXT_W){acc_in[ACC_W-1]}}, acc_in[ACC_W-1 -: EXT_W]};
      SEL_HIGH: next_word = acc_in[2*WORD_W-1:WORD_W];
      default:  next_word = acc_in[WORD_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_data    <= '0;
      bus_valid   <= 1'b0;
      flag_limit  <= 1'b0;
      flag_growth <= 1'b0;
    end else begin
      bus_valid <= rd_req;
      if (rd_req) bus_data <= next_word;
      if (flag_clr) begin
        flag_limit  <= 1'b0;
        flag_growth <= 1'b0;
      end else if (full_rd) begin
        flag_limit  <= flag_limit | over;
        flag_growth <= flag_growth | grow;
      end
    end
  end
endmodule

module acc_read_limiter_chk #(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 24
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      rd_req,
  input logic [1:0]                rd_sel,
  input logic                      flag_clr,
  input logic [WORD_W-1:0]         bus_data,
  input logic                      bus_valid,
  input logic                      flag_limit,
  input logic                      flag_growth
);
  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> bus_valid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !rd_req |=> !bus_valid); // R1
  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !rd_req |=> $stable(bus_data)); // R1
  AST_LIMIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flag_limit && !flag_clr) |=> flag_limit); // R4
  AST_GROWTH_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flag_growth && !flag_clr) |=> flag_growth); // R5
  AST_FIELD_READ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_sel != 2'd0 && !flag_clr) |=> ($stable(flag_limit) && $stable(flag_growth))); // R7
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n) flag_clr |=> (!flag_limit && !flag_growth)); // R8
endmodule

bind acc_read_limiter acc_read_limiter_chk #(.EXT_W(EXT_W), .WORD_W(WORD_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_sel(rd_sel), .flag_clr(flag_clr),
  .bus_data(bus_data), .bus_valid(bus_valid), .flag_limit(flag_limit), .flag_growth(flag_growth)
);

// File: tb/test_acc_read_limiter.sv
module test_acc_read_limiter;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0;
  logic [1:0]  rd_sel = 2'd0;
  logic        round_en = 1'b0;
  logic        flag_clr = 1'b0;
  logic [55:0] acc_in = '0;
  logic [23:0] bus_data;
  logic        bus_valid, flag_limit, flag_growth;

  int checks = 0;
  int errors = 0;
  bit exp_l = 0, exp_s = 0;

  typedef struct { logic [23:0] data; bit l; bit s; string tag; } item_t;
  item_t sb[$];

  acc_read_limiter i_acc_read_limiter (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_sel(rd_sel), .round_en(round_en),
    .flag_clr(flag_clr), .acc_in(acc_in), .bus_data(bus_data), .bus_valid(bus_valid),
    .flag_limit(flag_limit), .flag_growth(flag_growth)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Driver: apply one read (optionally with a clear) and push the expected result.
  task automatic do_read(string tag, logic [1:0] sel, bit rnd, logic [55:0] acc, bit clr = 0);
    item_t it;
    longint v, q;
    @(negedge clk);
    rd_req = 1; rd_sel = sel; round_en = rnd; acc_in = acc; flag_clr = clr;
    if (sel == 2'd0) begin
      v = longint'($signed(acc));
      if (rnd) v = v + 64'sd8388608;
      q = v >>> 24;
      if (q > 64'sd8388607) begin it.data = 24'h7FFFFF; if (!clr) exp_l = 1; end
      else if (q < -64'sd8388608) begin it.data = 24'h800000; if (!clr) exp_l = 1; end
      else it.data = q[23:0];
      if (acc[47] != acc[46] && !clr) exp_s = 1;
    end else if (sel == 2'd1) it.data = {{16{acc[55]}}, acc[55:48]};
    else if (sel == 2'd2) it.data = acc[47:24];
    else it.data = acc[23:0];
    if (clr) begin exp_l = 0; exp_s = 0; end
    it.l = exp_l; it.s = exp_s; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    rd_req = 0; flag_clr = 0;
    repeat (n - 1) @(negedge clk);
  endtask

  // Monitor: compare each valid result with the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && bus_valid) begin
      if (sb.size() == 0) check("R1 unexpected valid", 1, 0);
      else begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " data"}, bus_data, it.data);
        check({it.tag, " flags(L,S)"}, {flag_limit, flag_growth}, {it.l, it.s});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [23:0] held;
    repeat (2) @(negedge clk);
    check("R9 reset state", {bus_data, bus_valid, flag_limit, flag_growth}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1 no valid when idle", bus_valid, 0);

    do_read("R2 positive in range", 0, 0, 56'h00_123456_789ABC);
    do_read("R2 negative in range", 0, 0, 56'hFF_C65432_000000);
    do_read("R5 growth positive",   0, 0, 56'h00_400000_000000);
    do_read("R7 field read keeps S", 2, 0, 56'h00_111111_222222);
    do_read("R8 clear",              3, 0, 56'h00_000000_ABCDEF, 1);
    do_read("R3 R4 positive saturate", 0, 0, 56'h01_000000_000000);
    do_read("R4 sticky L",           0, 0, 56'h00_000010_000000);
    do_read("R8 clear2",             1, 0, 56'h00_000000_000000, 1);
    do_read("R3 negative saturate",  0, 0, 56'h80_000000_000000);
    do_read("R8 clear beats set",    0, 0, 56'h7F_000000_000000, 1);
    do_read("R6 round up",           0, 1, 56'h00_123456_800000);
    do_read("R6 round down",         0, 1, 56'h00_123456_7FFFFF);
    do_read("R6 no round same value", 0, 0, 56'h00_7FFFFF_800000);
    do_read("R6 round carry saturates", 0, 1, 56'h00_7FFFFF_800000);
    do_read("R8 clear3",             2, 0, 56'h00_000000_000000, 1);
    do_read("R6 negative round",     0, 1, 56'hFF_FFFFFF_FFFFFF);
    do_read("R7 ext sign-extended",  1, 1, 56'h80_FEDCBA_987654);
    do_read("R7 high unlimited",     2, 1, 56'h80_FEDCBA_987654);
    do_read("R7 low unrounded",      3, 1, 56'h80_FEDCBA_987654);
    do_read("R7 ext positive",       1, 0, 56'h35_000000_000000);
    idle(2);
    held = bus_data;
    idle(3);
    check("R1 data holds when idle", bus_data, held);
    check("R1 valid low when idle", bus_valid, 0);
    check("R1 scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule